// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synchronous model of a serial memory slave on a two-wire bus. The memory is a 128 x 8 byte array held in flops. SCL and SDA reach the block already filtered and synchronised to `clk_i`. The block answers the bus by pulling SDA low through an open-drain enable. Three strap inputs select one of eight bus positions, so up to eight copies can share one bus. A write-protect input blocks changes to the array and leaves reads working.

A master selects the device with a control byte and then does one of two things. It can send a word address followed by one or more data bytes. Or it reads from the current address, either directly or after setting the address and issuing a repeated start. Data bytes written in one transaction are gathered in a 16-byte page buffer. They go into the array when the master sends a Stop. After that the device runs a self-timed write cycle of `WRITE_CYCLES` clocks. During this cycle it does not acknowledge its control byte, so a master can poll for completion.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe_o` is low and every array byte reads 8'hFF.
- R2: The control byte is 1010 in bits 7:4, `strap_i[2:0]` in bits 3:1 and read/write in bit 0 (1 = read). The device pulls SDA low in the ninth clock only when bits 7:1 match. Otherwise it drives nothing until the next Start.
- R3: A byte write is a write control byte, a word address byte whose bits 6:0 are used, and one data byte. Each byte is acknowledged. The data is stored at that address when the Stop arrives.
- R4: In a page write, each data byte advances only address bits 3:0, wrapping inside the 16-byte page while bits 6:4 stay fixed. A 17th byte overwrites the first byte's location. No byte outside the page changes.
- R5: A Stop that ends a write with at least one data byte starts a busy period of `WRITE_CYCLES` clocks. During that period the control byte is not acknowledged. Afterwards it is acknowledged again.
- R6: While `wp_i` is high at the Stop, data bytes are still acknowledged, the array is unchanged, and no busy period starts.
- R7: A random read is a write control byte, a word address, a repeated Start and a read control byte. It returns the byte at that address, most significant bit first.
- R8: A read control byte with no preceding address returns the byte after the last one accessed. For a write, that is the byte after the last data byte, within its page.
- R9: In a sequential read, a master acknowledge moves on to the next address, rolling over from 127 to 0. A master no-acknowledge ends the read with SDA released.
- R10: The block only pulls SDA low or releases it, and its drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Filtered serial clock level |
| sda_i | input | 1 | Filtered serial data level (resolved bus) |
| strap_i | input | 3 | Bus position straps, compared with control byte bits 3:1 |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_oe_o | output | 1 | High pulls SDA low, low releases it |

## Verification
The bench addresses the device with a correct control byte, with a wrong strap value and with a wrong control code. This separates the full seven-bit compare from a partial one. Writes are tried as a single byte, as a page run that crosses the page end, and as a 17-byte overrun. Reading each of these back with random, current-address and sequential reads shows whether the low-nibble wrap and the row freeze work. The read at the top of the array separates a seven-bit rollover from a page-limited one. The same write pattern is repeated with write protect high, and the device is polled straight after each Stop. This tells a committed write and its busy window apart from an acknowledged but discarded one.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_END, S_ACK, S_TX, S_TX_ACK
  } bus_state_e;

  typedef enum logic [1:0] {
    K_DEV, K_WADDR, K_WDATA
  } rx_kind_e;

  localparam logic [3:0] CTRL_CODE = 4'b1010;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edges with SCL held high frame a transfer
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer #(
  parameter int CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = cnt_q != '0;

  p_busy_after_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_no_commit_while_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        rdata_o,
  input  logic              buf_we_i,
  input  logic [7:0]        buf_wdata_i,
  input  logic              clear_i,
  input  logic              commit_i,
  input  logic              wp_i,
  output logic              pending_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0]      mem_q  [DEPTH];
  logic [7:0]      pbuf_q [PAGE];
  logic [PAGE-1:0] pvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pvalid_q <= '0;
      for (int i = 0; i < PAGE; i++) pbuf_q[i] <= '0;
    end else if (clear_i) begin
      pvalid_q <= '0;
    end else if (buf_we_i) begin
      pbuf_q[addr_i[PAGE_W-1:0]]   <= buf_wdata_i;
      pvalid_q[addr_i[PAGE_W-1:0]] <= 1'b1;
    end
  end

  // Whole page lands in one cycle; row comes from the frozen upper address bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= 8'hFF;
    end else if (commit_i) begin
      for (int w = 0; w < DEPTH; w++) begin
        if (pvalid_q[w % PAGE] && (ADDR_W'(w) >> PAGE_W) == (addr_i >> PAGE_W))
          mem_q[w] <= pbuf_q[w % PAGE];
      end
    end
  end

  assign rdata_o   = mem_q[addr_i];
  assign pending_o = |pvalid_q;

  p_commit_unprotected_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !wp_i);
  p_commit_has_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> pending_o);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  logic scl_rise, scl_fall, start_det, stop_det;
  logic busy, pending, commit, buf_we, byte_end, dev_match;
  logic [7:0] rdata;

  bus_state_e        state_q;
  rx_kind_e          kind_q;
  logic [2:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [6:0]        tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q, mack_q, oe_q;

  i2c_bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i, .rst_ni,
    .addr_i(addr_q), .rdata_o(rdata),
    .buf_we_i(buf_we), .buf_wdata_i(sh_q),
    .clear_i(start_det | stop_det), .commit_i(commit),
    .wp_i, .pending_o(pending)
  );

  eeprom_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy)
  );

  assign byte_end  = (state_q == S_RX_END) && scl_fall;
  assign dev_match = sh_q[7:1] == {CTRL_CODE, strap_i};
  assign buf_we    = byte_end && (kind_q == K_WDATA);
  assign commit    = stop_det && pending && !wp_i;
  assign sda_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      state_q <= S_RX;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= S_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_RX: if (scl_rise) begin
          sh_q  <= {sh_q[6:0], sda_i};
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q == 3'd7) state_q <= S_RX_END;
        end
        S_RX_END: if (scl_fall) begin
          unique case (kind_q)
            K_DEV: if (dev_match && !busy) begin
              rw_q    <= sh_q[0];
              oe_q    <= 1'b1;
              state_q <= S_ACK;
            end else begin
              state_q <= S_IDLE;
            end
            K_WADDR: begin
              addr_q  <= sh_q[ADDR_W-1:0];
              oe_q    <= 1'b1;
              state_q <= S_ACK;
            end
            default: begin
              // data byte: acknowledged regardless of write protect
              addr_q  <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
              oe_q    <= 1'b1;
              state_q <= S_ACK;
            end
          endcase
        end
        S_ACK: if (scl_fall) begin
          cnt_q <= '0;
          if (kind_q == K_DEV && rw_q) begin
            tx_q    <= rdata[6:0];
            oe_q    <= ~rdata[7];
            state_q <= S_TX;
          end else begin
            oe_q    <= 1'b0;
            state_q <= S_RX;
            if (kind_q == K_DEV)        kind_q <= K_WADDR;
            else if (kind_q == K_WADDR) kind_q <= K_WDATA;
          end
        end
        S_TX: if (scl_fall) begin
          if (cnt_q == 3'd7) begin
            oe_q    <= 1'b0;
            addr_q  <= addr_q + ADDR_W'(1);
            state_q <= S_TX_ACK;
          end else begin
            tx_q  <= {tx_q[5:0], 1'b0};
            oe_q  <= ~tx_q[6];
            cnt_q <= cnt_q + 3'd1;
          end
        end
        S_TX_ACK: begin
          if (scl_rise) mack_q <= ~sda_i;
          if (scl_fall) begin
            if (mack_q) begin
              tx_q    <= rdata[6:0];
              oe_q    <= ~rdata[7];
              cnt_q   <= '0;
              state_q <= S_TX;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_ignore_foreign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && kind_q == K_DEV && !dev_match) |=> (state_q == S_IDLE && !sda_oe_o));
  p_nack_when_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && kind_q == K_DEV && busy) |=> !sda_oe_o);
  p_page_row_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));
  p_seq_advance_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TX && scl_fall && cnt_q == 3'd7 && !start_det && !stop_det)
      |=> addr_q == $past(addr_q) + ADDR_W'(1));
  p_drive_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_i));
endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
  localparam int WRITE_CYCLES = 500;
  localparam int Q = 4;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, m_sda, wp, sda_oe, sda_line;
  logic [2:0] strap;
  assign sda_line = m_sda & ~sda_oe;

  i2c_eeprom_slave #(.WRITE_CYCLES(WRITE_CYCLES)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t      exp_q[$];
  logic [7:0] act_q[$];
  int vectors = 0, errors = 0, r10_bad = 0;
  logic [7:0] model [128];
  logic [6:0] cur;
  logic last_oe = 1'b0, last_scl = 1'b1;
  bit done = 0;

  // scoreboard monitor
  always @(negedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t e;
      logic [7:0] a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      vectors++;
      if (a !== e.val) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h", e.tag, a, e.val);
      end
    end
  end

  // R10: drive may only change while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== last_oe && scl && last_scl) r10_bad++;
    last_oe  = sda_oe;
    last_scl = scl;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; clk_wait(Q);
    scl = 1'b1;   clk_wait(Q);
    m_sda = 1'b0; clk_wait(Q);
    scl = 1'b0;   clk_wait(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; clk_wait(Q);
    scl = 1'b1;   clk_wait(Q);
    m_sda = 1'b1; clk_wait(Q);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    m_sda = b; clk_wait(Q);
    scl = 1'b1; clk_wait(Q);
    s = sda_line;
    scl = 1'b0;
  endtask

  // ack bit value: 0 = acknowledged, 1 = not
  task automatic put_byte(input logic [7:0] d, input string tag, input logic exp_nack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    exp_q.push_back('{tag, {7'd0, exp_nack}});
    clock_bit(1'b1, s);
    act_q.push_back({7'd0, s});
  endtask

  task automatic get_byte(input logic [7:0] exp, input string tag, input logic mack);
    logic [7:0] d;
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    exp_q.push_back('{tag, exp});
    clock_bit(~mack, s);
    act_q.push_back(d);
  endtask

  task automatic write_run(input logic [6:0] a, input logic [7:0] first, input logic [7:0] step,
                           input int n, input string tag);
    bus_start();
    put_byte(DEV_W, "R2", 1'b0);
    put_byte({1'b0, a}, tag, 1'b0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      logic [6:0] idx;
      d   = first + step * 8'(i);
      idx = {a[6:4], 4'(a[3:0] + 4'(i))};
      put_byte(d, tag, 1'b0);
      if (!wp) model[idx] = d;
    end
    cur = {a[6:4], 4'(a[3:0] + 4'(n))};
    bus_stop();
  endtask

  task automatic read_seq(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      get_byte(model[cur], tag, i != n - 1);
      cur = cur + 7'd1;
    end
    bus_stop();
  endtask

  task automatic random_read(input logic [6:0] a, input int n, input string tag);
    bus_start();
    put_byte(DEV_W, "R2", 1'b0);
    put_byte({1'b0, a}, tag, 1'b0);
    bus_start();
    put_byte(DEV_R, "R2", 1'b0);
    cur = a;
    read_seq(n, tag);
  endtask

  task automatic current_read(input int n, input string tag);
    bus_start();
    put_byte(DEV_R, "R2", 1'b0);
    read_seq(n, tag);
  endtask

  task automatic poll(input string tag, input logic exp_nack);
    bus_start();
    put_byte(DEV_W, tag, exp_nack);
    bus_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      clk_wait(4);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    scl = 1'b1; m_sda = 1'b1; wp = 1'b0; strap = STRAP; rst_n = 1'b0; cur = '0;
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    clk_wait(5);
    check("R1", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    clk_wait(5);
    check("R1", {7'd0, sda_oe}, 8'h00);
    // R1 and R7: erased contents
    random_read(7'h00, 1, "R1");
    random_read(7'h7F, 1, "R7");

    // R2: foreign strap and foreign control code are ignored
    bus_start();
    put_byte(8'hA0, "R2", 1'b1);
    put_byte(8'h00, "R2", 1'b1);
    bus_stop();
    bus_start();
    put_byte(8'hAF, "R2", 1'b1);
    bus_stop();
    bus_start();
    put_byte(8'hBA, "R2", 1'b1);
    bus_stop();

    // R3 byte write and R5 busy window
    write_run(7'h05, 8'h3C, 8'h00, 1, "R3");
    poll("R5", 1'b1);
    clk_wait(WRITE_CYCLES + 20);
    poll("R5", 1'b0);
    random_read(7'h04, 3, "R3");

    // R4 page wrap, R8 current address
    write_run(7'h2E, 8'h11, 8'h11, 3, "R4");
    clk_wait(WRITE_CYCLES + 20);
    random_read(7'h2E, 1, "R4");
    current_read(1, "R8");
    random_read(7'h20, 1, "R4");
    random_read(7'h30, 1, "R4");

    // R4 overrun of 17 bytes, read back with R9 sequential read
    write_run(7'h40, 8'h80, 8'h01, 17, "R4");
    clk_wait(WRITE_CYCLES + 20);
    random_read(7'h40, 17, "R9");

    // R6 write protect
    wp = 1'b1;
    write_run(7'h05, 8'h77, 8'h00, 1, "R6");
    poll("R6", 1'b0);
    wp = 1'b0;
    random_read(7'h05, 1, "R6");

    // R9 rollover 127 -> 0
    write_run(7'h7F, 8'hA5, 8'h00, 1, "R9");
    clk_wait(WRITE_CYCLES + 20);
    write_run(7'h00, 8'h5A, 8'h00, 1, "R9");
    clk_wait(WRITE_CYCLES + 20);
    current_read(1, "R8");
    random_read(7'h7E, 3, "R9");
    check("R9", {7'd0, sda_oe}, 8'h00);

    check("R10", 8'(r10_bad), 8'h00);
    clk_wait(10);
    finish_run();
  end
endmodule